// File: doc/BRIEF.md
# Audio Control-Register Bus Slave

This block is a write-only two-wire serial bus slave. It sits in front of an audio processing core and fills a bank of ten 8-bit control registers. SCL and SDA come from the board pins and are sampled in the system clock domain. The slave acknowledges by pulling SDA low through an open-drain output. A strap input moves the device address by one step.

A host transfer has a fixed shape. It opens with START, sends the device address byte and then a subaddress byte. Any number of data bytes follow, and a STOP closes the transfer. Bit 7 of the subaddress is a step flag and its low four bits select a slot. The step flag decides how data bytes are placed:
- With the flag clear, every data byte goes to the same slot.
- With the flag set, the slot advances by one after each byte. It runs round a 16-slot loop in which slots 10 to 15 hold no register.

Each register comes out in parallel, together with a one-cycle write strobe.

Top module: `audio_ctl_slave`

## Requirements
- R1: After reset the register bytes read, from slot 0 to slot 9: 0x3F, 0x7E, 0x00, 0x1E, 0xFE, 0x78, 0x78, 0x78, 0x78, 0x1F. Register k appears on `regs_o[8k+7:8k]`. No strobe and no SDA pull are active after reset.
- R2: The slave acknowledges by asserting `sda_pull_o` during the ninth clock of a byte, and at no other time. The accepted address byte is 0x80 while `addr_strap_i` is 0 and 0x82 while it is 1. Its bit 0 must be 0, meaning a write.
- R3: An address byte that does not match gets no acknowledge. The slave then ignores the bus until the next START: it gives no acknowledge, not even to a later byte equal to its own address, and writes no register.
- R4: When subaddress bit 7 is 0, every data byte of the transfer is written to the slot named by subaddress bits 3..0. The register ends up holding the last byte sent.
- R5: When subaddress bit 7 is 1, the first data byte goes to the named slot and each later byte goes to the next slot. A byte aimed at slots 10..15 changes no register and raises no strobe, but it is still acknowledged.
- R6: In step mode the slot counter wraps from 15 to 0, so a long burst loops over the bank.
- R7: Subaddress bits 6..4 have no effect on which register is written.
- R8: Each accepted data byte for slots 0..9 raises exactly the strobe bit of that slot for one clock. At most one strobe bit is high at a time, and a register changes only in a cycle in which a strobe is high.
- R9: A START inside a transfer restarts address reception. A partly received byte is dropped without any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_strap_i | input | 1 | Address strap: 0 selects 0x80, 1 selects 0x82 |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| regs_o | output | REG_COUNT*8 | Register bank, slot k at bits 8k+7..8k |
| wstrobe_o | output | REG_COUNT | One-cycle write pulse per register |

## Verification
The bench builds the block with its default parameters: ten registers and a 4-bit slot counter. This leaves six empty slots, so the dropped-write path and the 15-to-0 wrap are both within reach.
- Every one of the 16 subaddresses is tried as a start point in both placement modes.
- In step mode, bursts of 17 bytes pass through the empty slots and wrap the counter from every start point.
- All 256 address bytes are swept against the strap setting, each followed by a byte equal to the valid address.
- One case cuts a byte in half with a repeated START.

// File: rtl/audio_ctl_slave.sv
module audio_ctl_slave #(
  parameter int REG_COUNT = 10,
  parameter int SLOT_BITS = 4,
  parameter logic [6:0] BASE_ADDR = 7'h40,
  parameter logic [REG_COUNT*8-1:0] RESET_VALUES = 80'h1F_78_78_78_78_FE_1E_00_7E_3F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic                   addr_strap_i,
  output logic                   sda_pull_o,
  output logic [REG_COUNT*8-1:0] regs_o,
  output logic [REG_COUNT-1:0]   wstrobe_o
);
  localparam int IDXW = $clog2(REG_COUNT);
  localparam logic [SLOT_BITS-1:0] SLOT_ONE = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_SUB, ST_DATA} st_t;

  logic [2:0] scl_q, sda_q;
  logic scl, scl_d, sda, sda_d;
  logic start_c, stop_c, scl_rise, scl_fall;
  logic [7:0] my_addr;

  st_t st;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic ack;
  logic inc;
  logic [SLOT_BITS-1:0] slot;
  logic [7:0] regs [REG_COUNT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  assign scl      = scl_q[1];
  assign scl_d    = scl_q[2];
  assign sda      = sda_q[1];
  assign sda_d    = sda_q[2];
  assign start_c  = scl & scl_d & sda_d & ~sda;
  assign stop_c   = scl & scl_d & ~sda_d & sda;
  assign scl_rise = scl & ~scl_d;
  assign scl_fall = ~scl & scl_d;
  assign my_addr  = {BASE_ADDR[6:1], BASE_ADDR[0] | addr_strap_i, 1'b0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ack       <= 1'b0;
      inc       <= 1'b0;
      slot      <= '0;
      wstrobe_o <= '0;
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= RESET_VALUES[i*8 +: 8];
    end else begin
      wstrobe_o <= '0;
      if (start_c) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        ack    <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        bitcnt <= '0;
        ack    <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise && !ack && bitcnt != 4'd8) begin
          shreg  <= {shreg[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end
        if (scl_fall) begin
          if (ack) begin
            ack    <= 1'b0;
            bitcnt <= '0;
          end else if (bitcnt == 4'd8) begin
            case (st)
              ST_ADDR:
                if (shreg == my_addr) begin
                  ack <= 1'b1;
                  st  <= ST_SUB;
                end else begin
                  st <= ST_IDLE;
                end
              ST_SUB: begin
                slot <= shreg[SLOT_BITS-1:0];
                inc  <= shreg[7];
                ack  <= 1'b1;
                st   <= ST_DATA;
              end
              default: begin
                ack <= 1'b1;
                if (32'(slot) < REG_COUNT) begin
                  regs[slot[IDXW-1:0]]      <= shreg;
                  wstrobe_o[slot[IDXW-1:0]] <= 1'b1;
                end
                if (inc) slot <= slot + SLOT_ONE;
              end
            endcase
          end
        end
      end
    end

  assign sda_pull_o = ack;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/audio_ctl_slave_chk.sv
module audio_ctl_slave_chk #(
  parameter int REG_COUNT = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [REG_COUNT-1:0]   wstb,
  input logic [REG_COUNT*8-1:0] regs,
  input logic                   pull,
  input logic [1:0]             st,
  input logic [3:0]             bitcnt
);
  assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wstb));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|wstb) |=> !(|wstb));

  assert_regs_need_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (regs != $past(regs)) |-> (|wstb));

  assert_ack_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |-> ($past(bitcnt) == 4'd8));

  assert_ack_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pull |-> (st != 2'd0));

  assert_strobe_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|wstb) |-> (st == 2'd3));
endmodule

bind audio_ctl_slave audio_ctl_slave_chk #(.REG_COUNT(REG_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wstb(wstrobe_o), .regs(regs_o),
  .pull(sda_pull_o), .st(st), .bitcnt(bitcnt));

// File: tb/audio_ctl_slave_test.sv
module audio_ctl_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam int NREG = 10;
  localparam int WATCHDOG = 190000;
  localparam logic [NREG*8-1:0] DEFAULTS = 80'h1F_78_78_78_78_FE_1E_00_7E_3F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_pull;
  logic [NREG*8-1:0] regs;
  logic [NREG-1:0] stb;
  wire sda_line = sda_m & ~sda_pull;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] exp_r [16];
  int exp_cnt [16];
  int seen_cnt [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_ctl_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap_i(strap), .sda_pull_o(sda_pull), .regs_o(regs), .wstrobe_o(stb));

  always @(negedge clk)
    if (rst_n)
      for (int k = 0; k < NREG; k++)
        if (stb[k]) seen_cnt[k]++;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb, output bit stray);
    stray = 1'b0;
    for (int i = 7; i >= 8 - nb; i--) begin
      sda_m = b[i]; qwait();
      scl_m = 1'b1; qwait();
      if (sda_pull) stray = 1'b1;
      qwait();
      scl_m = 1'b0; qwait();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit got, output bit stray);
    send_bits(b, 8, stray);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    got = !sda_line;
    qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic compare_all(input string req);
    for (int k = 0; k < NREG; k++) begin
      chk(regs[k*8 +: 8] == exp_r[k], req, int'(regs[k*8 +: 8]), int'(exp_r[k]));
      chk(seen_cnt[k] == exp_cnt[k], "R8 strobe count", seen_cnt[k], exp_cnt[k]);
    end
  endtask

  task automatic xfer(input logic [7:0] ab, input logic [7:0] sub, input int n,
                      input logic [7:0] seed, input string req);
    bit got, stray, match;
    logic [7:0] d;
    logic [3:0] slot;
    match = (ab == (strap ? 8'h82 : 8'h80));
    bus_start();
    send_byte(ab, got, stray);
    chk(got == match, "R2 address ack", int'(got), int'(match));
    send_byte(sub, got, stray);
    chk(got == match, req, int'(got), int'(match));
    slot = sub[3:0];
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 37);
      send_byte(d, got, stray);
      chk(got == match, req, int'(got), int'(match));
      chk(!stray, "R2 pull outside ack", int'(stray), 0);
      if (match) begin
        if (slot < NREG) begin
          exp_r[slot] = d;
          exp_cnt[slot]++;
        end
        if (sub[7]) slot = slot + 4'd1;
      end
    end
    bus_stop();
    repeat (4) @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit got, stray;
    for (int k = 0; k < 16; k++) begin
      exp_r[k] = (k < NREG) ? DEFAULTS[k*8 +: 8] : 8'h00;
      exp_cnt[k] = 0;
      seen_cnt[k] = 0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    compare_all("R1 reset value");
    chk(stb == '0, "R1 strobes idle", int'(stb), 0);
    chk(sda_pull == 1'b0, "R1 no pull", int'(sda_pull), 0);

    // R4 R7: fixed slot, bits 6..4 scrambled
    for (int s = 0; s < 16; s++)
      xfer(8'h80, {1'b0, 3'((s * 5) & 7), 4'(s)}, 3, 8'(s * 11 + 1), "R4 R7 fixed slot");

    // R5 R6: stepping bursts through dead slots and past the wrap
    for (int s = 0; s < 16; s++)
      xfer(8'h80, {1'b1, 3'((s * 3) & 7), 4'(s)}, 17, 8'(s * 19 + 7), "R5 R6 step burst");

    // R2: strap high moves the address
    strap = 1'b1;
    repeat (4) @(negedge clk);
    xfer(8'h82, 8'h85, 3, 8'h21, "R2 strap high");
    xfer(8'h80, 8'h02, 2, 8'h44, "R2 R3 old address rejected");
    strap = 1'b0;
    repeat (4) @(negedge clk);

    // R3: every other address byte is ignored for the whole transfer
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h80) begin
        bus_start();
        send_byte(8'(a), got, stray);
        chk(!got, "R3 foreign address", int'(got), 0);
        send_byte(8'h80, got, stray);
        chk(!got, "R3 ignored until START", int'(got), 0);
        bus_stop();
      end
    end
    repeat (4) @(negedge clk);
    compare_all("R3 no write");

    // R9: repeated START cuts a partial byte
    bus_start();
    send_byte(8'h80, got, stray);
    send_byte(8'h03, got, stray);
    send_byte(8'h5A, got, stray);
    exp_r[3] = 8'h5A; exp_cnt[3]++;
    send_bits(8'hF0, 4, stray);
    bus_start();
    send_byte(8'h80, got, stray);
    chk(got, "R9 address after restart", int'(got), 1);
    send_byte(8'h84, got, stray);
    send_byte(8'hC3, got, stray);
    exp_r[4] = 8'hC3; exp_cnt[4]++;
    bus_stop();
    repeat (4) @(negedge clk);
    compare_all("R9 restart");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule